// File: doc/BRIEF.md
# Pin Bank Controller with Edge Interrupts

This block is a general-purpose I/O bank of 28 pins behind a small 32-bit register bus. Software selects per pin whether the pad is driven, moves the output latch with separate write-one-to-set and write-one-to-clear registers, and reads back the synchronized pin state. An alternate-function word is stored for a neighbouring pad multiplexer. It is not acted on here.

Each pin can record rising and/or falling transitions into a sticky status word. Software clears that word by writing ones to it. Pins 0 to 10 each raise their own interrupt line from their status bit. Pins 11 to 27 share one combined line. Pad inputs pass through a two-flop synchronizer before they are read back or edge-detected. The bus is read combinationally: `bus_rdata` reflects `bus_addr` in the same cycle. Writes take effect at the clock edge where `bus_we` is high.

Top module: `pinbank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: every register readback, `pad_oe`, `pad_out`, `irq_pin` and `irq_shared`.
- R2: A write to offset 0x08 raises the output latch bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value. `pad_out` shows the change one clock after the write.
- R3: A write to offset 0x0C lowers the output latch bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value. `pad_out` shows the change one clock after the write.
- R4: The direction register at offset 0x04 reads back as written, with bit value 1 meaning output. `pad_oe` equals this register. The output latch keeps its value while a pin is an input.
- R5: Offset 0x00 reads the pin state after a two-flop synchronizer. A pad change set up before clock edge k is visible after edge k+1.
- R6: With the pin's bit set in the rising-enable register (offset 0x10), a low-to-high transition sets the pin's status bit. For a pad change before edge k, the status bit is set at edge k+2.
- R7: With the pin's bit set in the falling-enable register (offset 0x14), a high-to-low transition sets the status bit. A transition in a direction that is not enabled sets nothing. With both enables set, either direction sets the bit.
- R8: The status register at offset 0x18 is sticky. Writing a 1 to a bit clears it, and writing 0 bits has no effect.
- R9: If an edge is detected in the same cycle that a write clears that status bit, the bit stays set.
- R10: `irq_pin[i]` equals status bit i for pins 0 to 10. `irq_shared` is the OR of status bits 11 to 27.
- R11: The alternate-function register at offset 0x1C stores and reads back its 28 bits. It has no effect on pads or interrupts.
- R12: Bits 31 to 28 of every register read as zero and ignore writes. The set register, the clear register and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 28 | Pin level from the pads (asynchronous) |
| pad_out | output | 28 | Output latch to the pads |
| pad_oe | output | 28 | Per-pin drive enable |
| irq_pin | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt for pins 11 to 27 |

## Verification
Register writes are due one edge after the write strobe. Pin level readback is due two edges after a pad change. Edge status and its interrupt lines are due three edges after a pad change. The bench drives every stimulus on the falling clock edge and counts the rising edges to the due cycle before it samples. For edge detection, it also samples one edge early and expects the old value, so a result that arrives late or early is caught. The test of an edge that coincides with a clear places the write strobe on exactly the edge where detection lands.

// File: rtl/pinbank_pkg.sv
// Shared constants for the pin bank controller: bus widths and register offsets.
// Assumes byte addressing with 32-bit registers on 4-byte boundaries.
package pinbank_pkg;
    localparam int BUS_AW = 8;
    localparam int DATA_W = 32;

    localparam logic [BUS_AW-1:0] OFS_LEVEL = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_DIR   = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_SET   = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_CLR   = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_RISE  = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_FALL  = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_EDGE  = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_ALT   = 8'h1C;
endpackage

// File: rtl/pinbank_sync.sv
// Two-flop synchronizer for the pad inputs, plus one more stage that holds
// the previous synchronized value for edge detection.
// Assumes pad_in is asynchronous and each bit is independent.
module pinbank_sync #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    // Shift the pad levels through the metastability and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/pinbank_edge.sv
// Per-pin sticky edge status. A pin sets its bit on an enabled transition.
// A write of ones clears bits. A new event wins over a clear in the same cycle.
// Assumes sync_q and prev_q come from consecutive stages of one clock domain.
module pinbank_edge #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_q,
    input  logic [W-1:0] prev_q,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic evt;

            // Detect an enabled transition on this pin.
            always_comb evt = (rise_en[g] &  sync_q[g] & ~prev_q[g])
                            | (fall_en[g] & ~sync_q[g] &  prev_q[g]);

            // Hold the status bit until it is cleared; an event in the same cycle keeps it set.
            always_ff @(posedge clk) begin
                if (!rst_n) status[g] <= 1'b0;
                else        status[g] <= (status[g] & ~clr_mask[g]) | evt;
            end
        end
    endgenerate
endmodule

// File: rtl/pinbank_irq.sv
// Interrupt fan-out. Low-numbered pins each get a dedicated line and the
// rest are ORed onto one shared line.
// Assumes 0 < NUM_DED < W.
module pinbank_irq #(
    parameter int W       = 28,
    parameter int NUM_DED = 11
) (
    input  logic [W-1:0]       status,
    output logic [NUM_DED-1:0] irq_pin,
    output logic               irq_shared
);
    genvar g;
    generate
        for (g = 0; g < NUM_DED; g++) begin : g_ded
            // Dedicated line follows its own status bit.
            assign irq_pin[g] = status[g];
        end
    endgenerate

    // Combine the remaining pins onto the shared line.
    assign irq_shared = |status[W-1:NUM_DED];
endmodule

// File: rtl/pinbank_ctrl.sv
// Pin bank controller top: register decode, direction, output latch and
// alternate-function storage. Instantiates the synchronizer, the edge status
// and the interrupt fan-out.
// Assumes NUM_PINS < DATA_W, a single bus master and combinational reads.
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 28,
    parameter int NUM_DED  = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_DED-1:0]  irq_pin,
    output logic                irq_shared
);
    localparam int PAD_W = DATA_W - NUM_PINS;

    logic [NUM_PINS-1:0] wmask;
    logic [NUM_PINS-1:0] dir_q, out_q, rise_q, fall_q, alt_q;
    logic [NUM_PINS-1:0] sync_q, prev_q, edge_status, clr_mask;
    logic [NUM_PINS-1:0] set_m, clr_m, rd_bits;
    logic                wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_edge, wr_alt;

    // Decode the write strobes per register.
    always_comb begin
        wmask   = bus_wdata[NUM_PINS-1:0];
        wr_dir  = bus_we && (bus_addr == OFS_DIR);
        wr_set  = bus_we && (bus_addr == OFS_SET);
        wr_clr  = bus_we && (bus_addr == OFS_CLR);
        wr_rise = bus_we && (bus_addr == OFS_RISE);
        wr_fall = bus_we && (bus_addr == OFS_FALL);
        wr_edge = bus_we && (bus_addr == OFS_EDGE);
        wr_alt  = bus_we && (bus_addr == OFS_ALT);
        set_m    = wr_set  ? wmask : '0;
        clr_m    = wr_clr  ? wmask : '0;
        clr_mask = wr_edge ? wmask : '0;
    end

    // Store the configuration registers and the output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            alt_q  <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wmask;
            if (wr_rise) rise_q <= wmask;
            if (wr_fall) fall_q <= wmask;
            if (wr_alt)  alt_q  <= wmask;
            out_q <= (out_q | set_m) & ~clr_m;
        end
    end

    // Select the read data; write-only and unmapped offsets return zero.
    always_comb begin
        case (bus_addr)
            OFS_LEVEL: rd_bits = sync_q;
            OFS_DIR:   rd_bits = dir_q;
            OFS_RISE:  rd_bits = rise_q;
            OFS_FALL:  rd_bits = fall_q;
            OFS_EDGE:  rd_bits = edge_status;
            OFS_ALT:   rd_bits = alt_q;
            default:   rd_bits = '0;
        endcase
        bus_rdata = {{PAD_W{1'b0}}, rd_bits};
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    pinbank_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    pinbank_edge #(.W(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_q   (sync_q),
        .prev_q   (prev_q),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .clr_mask (clr_mask),
        .status   (edge_status)
    );

    pinbank_irq #(.W(NUM_PINS), .NUM_DED(NUM_DED)) u_irq (
        .status     (edge_status),
        .irq_pin    (irq_pin),
        .irq_shared (irq_shared)
    );
endmodule

// File: rtl/pinbank_ctrl_chk.sv
// Property checker for pinbank_ctrl, attached with bind below.
// Assumes the bus is idle (bus_we low) while reset is held.
module pinbank_ctrl_chk
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 28,
    parameter int NUM_DED  = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic [BUS_AW-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] edge_status,
    input logic [NUM_DED-1:0]  irq_pin,
    input logic                irq_shared
);
    // R12: the unimplemented upper bits never read as one.
    a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_PINS] == '0);

    // R4: drive enables change only after a direction write.
    a_r4_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(bus_we) && $past(bus_addr) == OFS_DIR) |-> $stable(pad_oe));

    // R2 and R3: the output latch changes only after a set or clear write.
    a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(bus_we) && ($past(bus_addr) == OFS_SET || $past(bus_addr) == OFS_CLR))
        |-> $stable(pad_out));

    // R8: status bits drop only after a write to the status register.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(bus_we) && $past(bus_addr) == OFS_EDGE)
        |-> ((~edge_status & $past(edge_status)) == '0));

    // R10: with no status pending, no interrupt line is raised.
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_status == '0) |-> (irq_pin == '0 && !irq_shared));
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NUM_PINS(NUM_PINS), .NUM_DED(NUM_DED)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .edge_status (edge_status),
    .irq_pin     (irq_pin),
    .irq_shared  (irq_shared)
);

// File: tb/pinbank_ctrl_tb_top.sv
// Self-checking bench for pinbank_ctrl: a register vector table, then
// directed tests for reset, edges, sticky status and interrupt routing.
module pinbank_ctrl_tb_top;
    localparam int NP = 28;
    localparam int ND = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in, pad_out, pad_oe;
    logic [NP-1:0] ext = '0;
    logic [ND-1:0] irq_pin;
    logic          irq_shared;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // Pad model: a driven pin loops back, otherwise the external level is seen.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    pinbank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_pin(irq_pin), .irq_shared(irq_shared)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    // Write, wait three cycles, read one register; external pads held low.
    localparam vec_t VECS [8] = '{
        '{8'd4,  8'h04, 32'hFFFF_FFFF, 8'h04, 32'h0FFF_FFFF}, // R4 R12 direction readback
        '{8'd2,  8'h08, 32'h0000_00F0, 8'h00, 32'h0000_00F0}, // R2 R5 set drives level
        '{8'd3,  8'h0C, 32'h0000_0030, 8'h00, 32'h0000_00C0}, // R3 clear some
        '{8'd12, 8'h08, 32'hF000_0000, 8'h08, 32'h0000_0000}, // R12 set reads zero
        '{8'd11, 8'h1C, 32'hABCD_1234, 8'h1C, 32'h0BCD_1234}, // R11 alternate function
        '{8'd4,  8'h04, 32'h0000_0000, 8'h00, 32'h0000_0000}, // R4 inputs see pads
        '{8'd4,  8'h04, 32'h0000_00FF, 8'h00, 32'h0000_00C0}, // R4 latch kept
        '{8'd12, 8'h20, 32'h0000_1234, 8'h20, 32'h0000_0000}  // R12 unmapped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick(1);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1: reset values on every register and output.
        for (int a = 0; a < 8; a++) begin
            rd(8'(a * 4), v);
            check("R1 reset readback", v, 32'h0);
        end
        check("R1 reset pad_oe", 32'(pad_oe), 32'h0);
        check("R1 reset pad_out", 32'(pad_out), 32'h0);
        check("R1 reset irq", {20'h0, irq_shared, irq_pin}, 32'h0);

        // Register vector table (R2 R3 R4 R5 R11 R12).
        for (int i = 0; i < 8; i++) begin
            wr(VECS[i].waddr, VECS[i].wdata);
            tick(2);
            rd(VECS[i].raddr, v);
            check($sformatf("R%0d table entry %0d", VECS[i].req, i), v, VECS[i].exp);
        end
        check("R11 alt has no pad effect", 32'(pad_oe), 32'h0000_00FF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0);
        tick(3);
        rd(8'h18, v);
        check("R7 no status without enables", v, 32'h0);

        // R5: level due two edges after the pad change.
        ext[9] = 1'b1;
        tick(1); rd(8'h00, v);
        check("R5 level not yet", v, 32'h0);
        tick(1); rd(8'h00, v);
        check("R5 level after sync", v, 32'h0000_0200);
        ext[9] = 1'b0; tick(3);

        // R6 R10: rising edge on pin 3 due at the third edge.
        wr(8'h10, 32'h0000_8098);   // rise on 3, 4, 7, 15
        wr(8'h14, 32'h0000_00A0);   // fall on 5, 7
        ext[3] = 1'b1;
        tick(2);
        check("R6 pin3 irq early", 32'(irq_pin[3]), 32'h0);
        tick(1);
        check("R6 pin3 irq due", 32'(irq_pin[3]), 32'h1);
        rd(8'h18, v);
        check("R6 status pin3", v, 32'h0000_0008);

        // R8: writing zeros keeps, writing a one clears.
        wr(8'h18, 32'h0);
        rd(8'h18, v);
        check("R8 zero write keeps", v, 32'h0000_0008);
        wr(8'h18, 32'h0000_0008);
        rd(8'h18, v);
        check("R8 one write clears", v, 32'h0);

        // R7: falling on pin 3 with only rise enabled sets nothing.
        ext[3] = 1'b0; tick(4);
        rd(8'h18, v);
        check("R7 unenabled fall ignored", v, 32'h0);
        ext[5] = 1'b1; tick(4);
        rd(8'h18, v);
        check("R7 unenabled rise ignored", v, 32'h0);
        ext[5] = 1'b0; tick(3);
        check("R7 R10 pin5 fall irq", 32'(irq_pin), 32'h0000_0020);
        wr(8'h18, 32'hFFFF_FFFF);
        ext[7] = 1'b1; tick(3);
        rd(8'h18, v);
        check("R7 both enables rise", v, 32'h0000_0080);
        wr(8'h18, 32'h0000_0080);
        ext[7] = 1'b0; tick(3);
        rd(8'h18, v);
        check("R7 both enables fall", v, 32'h0000_0080);
        wr(8'h18, 32'hFFFF_FFFF);

        // R10: pin 15 goes to the shared line only.
        ext[15] = 1'b1; tick(3);
        check("R10 shared irq", {20'h0, irq_shared, irq_pin}, 32'h0000_0800);
        wr(8'h18, 32'h0000_8000);
        check("R10 shared irq cleared", 32'(irq_shared), 32'h0);

        // R9: a new edge on pin 4 in the same cycle as its clear wins.
        ext[4] = 1'b1; tick(4);
        ext[4] = 1'b0; tick(4);
        rd(8'h18, v);
        check("R9 setup pending", v, 32'h0000_0010);
        ext[4] = 1'b1;
        tick(2);
        wr(8'h18, 32'h0000_0010);
        rd(8'h18, v);
        check("R9 edge beats clear", v, 32'h0000_0010);
        wr(8'h18, 32'h0000_0010);
        rd(8'h18, v);
        check("R9 later clear works", v, 32'h0);

        done = 1;
        summary();
        $finish;
    end
endmodule